// File: doc/BRIEF.md
# Odd-Parity Asynchronous Serial Transmitter

This block sends one character per request on a single asynchronous serial line. A frame is a low start bit, eight data bits sent least significant bit first, an odd parity bit and a high stop bit. Between frames the line rests high. With the default 100 MHz clock and 19,200 bit/s line rate, each bit lasts 5208 clock cycles (100e6 / 19,200, rounded down).

A client drives the character onto `tx_byte_i` and raises `req_i`. A request that lasts a single cycle is enough. The block captures the byte on the clock edge that accepts the request, and later changes on `tx_byte_i` have no effect on that frame. When the stop bit ends, `ack_o` rises. It stays high until `req_i` is low, and the block then returns to idle.

Inside, a control state machine drives a free-running bit-period timer, a data-bit counter and a datapath whose line output is a register.

Top module: `uart_tx_odd`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `tx_o` is 1 and `ack_o` is 0. Asserting reset in the middle of a frame returns the line to 1 and `ack_o` to 0.
- R2: When the request is accepted at a clock edge, `tx_o` is still 1 after that edge. `tx_o` goes low after the next edge.
- R3: Every bit of the frame, the start bit included, holds `tx_o` for exactly CLK_HZ/BAUD cycles. The bit timer wraps to zero by itself after its last cycle.
- R4: The frame order is: start bit 0, then eight data bits, then the parity bit, then stop bit 1. There are exactly eight data bits.
- R5: The parity bit equals the inverse of the XOR of the eight data bits, so data plus parity carry an odd number of ones. For example, 0x47 gives 1 and 0x00 gives 1.
- R6: Data bit i is `tx_byte_i[i]` as sampled at the accepting edge, sent LSB first. Changes to `tx_byte_i` after that edge do not alter the frame.
- R7: `ack_o` rises 11*CLK_HZ/BAUD cycles after the accepting edge. It stays high while `req_i` is high and falls one cycle after `req_i` is seen low.
- R8: A request held high through and past the frame does not start a second frame. `tx_o` stays 1 while `ack_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Frame request |
| tx_byte_i | input | 8 | Character to send |
| ack_o | output | 1 | Frame complete, held until the request drops |
| tx_o | output | 1 | Registered serial line |

## Verification
A timer that fails to wrap, or that wraps late, shifts every later bit boundary. A per-cycle compare of `tx_o` shows this within one bit period. A wrong bit count or bit index shows up as a wrong data or parity value at the first affected bit, and it also moves the `ack_o` rise away from cycle 11*N. The bench runs the datapath at 8 cycles per bit and compares the line and the acknowledge on every cycle of every frame, for all 256 byte values. Half of the frames use a single-cycle request and half use a held request.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_ACK
  } tx_state_e;

  typedef enum logic [1:0] {
    LINE_MARK, LINE_START, LINE_DATA, LINE_PARITY
  } line_sel_e;
endpackage

// File: rtl/uart_baud_timer.sv
module uart_baud_timer #(
  parameter int unsigned BIT_CYCLES = 5208
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned TMR_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [TMR_W-1:0] LAST = TMR_W'(BIT_CYCLES - 1);

  logic [TMR_W-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || done_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/uart_bit_counter.sv
module uart_bit_counter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      inc_i,
  output logic [$clog2(DATA_W)-1:0] idx_o,
  output logic                      done_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] cnt_q;

  assign idx_o  = cnt_q;
  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  no_bit_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !inc_i);
endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [DATA_W-1:0]         byte_i,
  input  line_sel_e                 sel_i,
  input  logic [$clog2(DATA_W)-1:0] idx_i,
  output logic                      tx_o
);
  logic [DATA_W-1:0] byte_q;
  logic              tx_q;
  logic              tx_d;

  always_comb begin
    unique case (sel_i)
      LINE_START:  tx_d = 1'b0;
      LINE_DATA:   tx_d = byte_q[idx_i];
      LINE_PARITY: tx_d = ~^byte_q;
      default:     tx_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      tx_q   <= 1'b1;
    end else begin
      if (load_i) byte_q <= byte_i;
      tx_q <= tx_d;
    end
  end

  assign tx_o = tx_q;

  // R5
  odd_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == LINE_PARITY) |=> ($countones({byte_q, tx_o}) % 2 == 1));
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == LINE_START) |=> !tx_o);
endmodule

// File: rtl/uart_tx_odd.sv
module uart_tx_odd
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned BAUD   = 19_200,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              ack_o,
  output logic              tx_o
);
  localparam int unsigned BIT_CYCLES = CLK_HZ / BAUD;
  localparam int unsigned IDX_W      = $clog2(DATA_W);

  tx_state_e        state_q, state_d;
  line_sel_e        sel;
  logic             tmr_clr, tmr_done;
  logic             bit_clr, bit_inc, bit_done;
  logic [IDX_W-1:0] bit_idx;
  logic             load;

  uart_baud_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .done_o(tmr_done)
  );

  uart_bit_counter #(.DATA_W(DATA_W)) u_bits (
    .clk_i, .rst_ni, .clr_i(bit_clr), .inc_i(bit_inc),
    .idx_o(bit_idx), .done_o(bit_done)
  );

  uart_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i, .rst_ni, .load_i(load), .byte_i(tx_byte_i),
    .sel_i(sel), .idx_i(bit_idx), .tx_o
  );

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    bit_clr = 1'b0;
    bit_inc = 1'b0;
    load    = 1'b0;
    sel     = LINE_MARK;
    unique case (state_q)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        bit_clr = 1'b1;
        if (req_i) begin
          load    = 1'b1;
          state_d = ST_START;
        end
      end
      ST_START: begin
        sel = LINE_START;
        if (tmr_done) begin
          bit_clr = 1'b1;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        sel = LINE_DATA;
        if (tmr_done) begin
          if (bit_done) state_d = ST_PARITY;
          else          bit_inc = 1'b1;
        end
      end
      ST_PARITY: begin
        sel = LINE_PARITY;
        if (tmr_done) state_d = ST_STOP;
      end
      ST_STOP: if (tmr_done) state_d = ST_ACK;
      ST_ACK: begin
        tmr_clr = 1'b1;
        if (!req_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ack_o = (state_q == ST_ACK);

  // R7
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i) |=> ack_o);
  // R7
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !req_i) |=> !ack_o);
  // R8
  line_idle_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ack_o) |-> tx_o);
endmodule

// File: tb/uart_tx_odd_tb.sv
module uart_tx_odd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int FRAME      = 11 * N;
  localparam int WDOG       = 150_000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic       ack_o, tx_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_tx_odd #(.CLK_HZ(N), .BAUD(1), .DATA_W(8)) u_dut (
    .clk_i, .rst_ni, .req_i, .tx_byte_i, .ack_o, .tx_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == WDOG) begin
      errors++;
      $display("FAIL watchdog: act=%0d expected<%0d cycles", cycles, WDOG);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_line(input logic [7:0] b, input int t);
    int i;
    if (t == 0) return 1'b1;
    i = (t - 1) / N;
    if (i == 0) return 1'b0;
    if (i <= 8) return b[i-1];
    if (i == 9) return ~^b;
    return 1'b1;
  endfunction

  function automatic string tag_for(input int t);
    int i;
    if (t <= 1) return "R2";
    if ((t - 1) % N == 0) return "R3";
    i = (t - 1) / N;
    if (i == 0 || i == 10) return "R4";
    if (i <= 8) return "R6";
    return "R5";
  endfunction

  // t counts negedges after the accepting edge
  task automatic frame(input logic [7:0] b, input bit hold);
    @(negedge clk_i);
    tx_byte_i = b;
    req_i = 1'b1;
    for (int t = 0; t <= FRAME + 3; t++) begin
      @(negedge clk_i);
      if (t == 0) begin
        tx_byte_i = ~b;
        if (!hold) req_i = 1'b0;
      end
      if (t < FRAME) begin
        chk(tag_for(t), tx_o, exp_line(b, t));
        chk("R7", ack_o, 0);
      end else if (hold) begin
        chk("R8", tx_o, 1);
        chk("R7", ack_o, 1);
      end else begin
        chk("R4", tx_o, 1);
        chk("R7", ack_o, (t == FRAME) ? 1 : 0);
      end
    end
    if (hold) begin
      req_i = 1'b0;
      @(negedge clk_i);
      chk("R7", ack_o, 0);
      chk("R8", tx_o, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", tx_o, 1);
    chk("R1", ack_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R1", tx_o, 1);
    chk("R1", ack_o, 0);

    for (int b = 0; b < 256; b++) frame(8'(b), b[0]);

    // reset in the middle of a frame
    @(negedge clk_i);
    tx_byte_i = 8'h00;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3 * N) @(negedge clk_i);
    chk("R4", tx_o, 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", tx_o, 1);
    chk("R1", ack_o, 0);
    rst_ni = 1'b1;
    repeat (FRAME + 4) begin
      @(negedge clk_i);
      chk("R1", tx_o, 1);
    end
    frame(8'h47, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule